// File: doc/BRIEF.md
# DTMF Steering Qualifier and Digit Latch

This block sits behind a tone-pair classifier and decides when a detected key press is genuine. It takes a raw "tone seen" flag plus the row and column index of the pair. It times how long the flag stays up and how long it stays down using two guard counters clocked by a 1 ms tick. The lengths of the two guard windows come from configuration inputs. The guard windows replace an external resistor-capacitor timing network. Once a tone has been present for the full present-guard window, the key is encoded into a 4-bit code and latched. A level valid flag is then raised, and a fixed-length low-going strobe is emitted.

The valid flag drops only after the tone has been absent for the full absent-guard window. A short gap in the tone is therefore bridged. The latched code stays put until the next accepted tone. The code bus can be released to high impedance so that it can share a bus with other devices.

The default strobe length is 10 ms. With a classifier whose detection delay is counted into the windows, the guard inputs are set so that key presses and pauses of 42 ms or more are accepted and those of 20 ms or less are rejected.

Top module: `dtmf_steer`

## Requirements
- R1: `early_o` is the tone flag delayed by one register. It is high in the cycle after `tone_hit` is high and low in the cycle after `tone_hit` is low.
- R2: A tone is accepted, and `guard_o` rises, on the tick at which it has been counted present for `hold_on_ms` ticks. A tone that goes away after fewer ticks is never accepted: `valid_o` stays low and the code is unchanged.
- R3: On acceptance the code is latched in the same clock as `guard_o` rises. `valid_o` rises one clock later, so the code is already stable in the cycle in which `valid_o` rises.
- R4: An accepted tone is released, and `guard_o` falls, on the tick at which it has been counted absent for `hold_off_ms` ticks. A shorter dropout leaves `valid_o` high and produces no new strobe. A dropout of exactly `hold_off_ms` ticks releases, and the next tone is accepted as a new key.
- R5: After release, the latched code keeps its value until the next acceptance.
- R6: Key encoding from (row, column), both indices 0 to 3. Row 0 holds 1,2,3,A; row 1 holds 4,5,6,B; row 2 holds 7,8,9,C; row 3 holds *,0,#,D. Digits 1 to 9 give their binary value. 0 gives 1010, * gives 1011, # gives 1100, A/B/C give 1101/1110/1111, and D gives 0000.
- R7: `valid_n_pulse_o` idles high. It goes low in the same cycle that `valid_o` rises and stays low for exactly `PULSE_MS` ticks: with a tick every T clocks, that is PULSE_MS·T−1 consecutive low cycles, the count used when the tone starts just before a tick.
- R8: With `out_en` high, `digit_o` drives the latched code. With `out_en` low, all four bits are high impedance.
- R9: An asynchronous active-low reset, released through a two-stage synchronizer, clears the code to 0000. It holds `valid_o`, `guard_o` and `early_o` low and `valid_n_pulse_o` high.
- R10: `valid_o` follows `guard_o` delayed by one clock, both on rising and on falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| tone_hit | input | 1 | Classifier reports a valid tone pair |
| row_idx | input | 2 | Low-group index from the classifier |
| col_idx | input | 2 | High-group index from the classifier |
| hold_on_ms | input | GW | Present-guard length in ticks |
| hold_off_ms | input | GW | Absent-guard length in ticks |
| out_en | input | 1 | Drive enable for the code bus |
| early_o | output | 1 | Early-steering flag |
| guard_o | output | 1 | Guard state, high while a tone is held as accepted |
| digit_o | output | 4 | Latched key code, tristated |
| valid_o | output | 1 | Data-valid level |
| valid_n_pulse_o | output | 1 | Active-low data-valid strobe |

## Verification
Code latching and the valid rise fall in adjacent cycles, as do a dropout ending and the absent window expiring on the same tick. The bench aligns each tone edge to just before a tick, so that tone and pause lengths are exact tick counts. It sweeps durations across both guard limits, including a dropout one tick short of the absent window and one exactly equal to it. A monitor checks at every valid rise that the code was already present one cycle earlier. It also counts strobe pulses and measures each pulse's length in cycles, so that a bridged dropout that wrongly re-strobes, or a missed re-acceptance, shows up in the count.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

  localparam int unsigned KEY_W = 4;

  typedef logic [KEY_W-1:0] key_code_t;

  // Keypad position to 4-bit code.
  function automatic key_code_t key_of(input logic [1:0] row, input logic [1:0] col);
    key_code_t k;
    if (col == 2'd3) begin
      k = (row == 2'd3) ? 4'd0 : (4'd13 + {2'b00, row});
    end else if (row == 2'd3) begin
      case (col)
        2'd0:    k = 4'd11;
        2'd1:    k = 4'd10;
        default: k = 4'd12;
      endcase
    end else begin
      k = {1'b0, row, 1'b0} + {2'b00, row} + {2'b00, col} + 4'd1;
    end
    return k;
  endfunction

endpackage

// File: rtl/dtmf_rst_sync.sv
module dtmf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic s0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q    <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      s0_q    <= 1'b1;
      rst_s_n <= s0_q;
    end
  end
endmodule

// File: rtl/dtmf_guard.sv
module dtmf_guard #(
  parameter int unsigned GW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          present,
  input  logic [GW-1:0] on_thr,
  input  logic [GW-1:0] off_thr,
  output logic          held,
  output logic          take
);
  logic [GW-1:0] cnt_q;
  logic [GW-1:0] cnt_d;
  logic          held_d;
  logic [GW:0]   cnt_inc;
  logic [GW-1:0] thr;
  logic          run;

  // One counter serves both windows: it counts the condition that would
  // flip the current state and clears whenever that condition lapses.
  always_comb begin
    held_d  = held;
    cnt_d   = cnt_q;
    take    = 1'b0;
    run     = held ? ~present : present;
    thr     = held ? off_thr : on_thr;
    cnt_inc = {1'b0, cnt_q} + {{GW{1'b0}}, 1'b1};
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_inc >= {1'b0, thr}) begin
        held_d = ~held;
        cnt_d  = '0;
        take   = ~held;
      end else begin
        cnt_d = cnt_inc[GW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      held  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      held  <= held_d;
    end
  end
endmodule

// File: rtl/dtmf_pulse.sv
module dtmf_pulse #(
  parameter int unsigned PULSE_MS = 10,
  localparam int unsigned CW = $clog2(PULSE_MS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  output logic pulse_n
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = CW'(PULSE_MS);
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - {{(CW-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse_n = (cnt_q == '0);
endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
  import dtmf_steer_pkg::*;
#(
  parameter int unsigned GW       = 6,
  parameter int unsigned PULSE_MS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_ms,
  input  logic          tone_hit,
  input  logic [1:0]    row_idx,
  input  logic [1:0]    col_idx,
  input  logic [GW-1:0] hold_on_ms,
  input  logic [GW-1:0] hold_off_ms,
  input  logic          out_en,
  output logic          early_o,
  output logic          guard_o,
  output logic [3:0]    digit_o,
  output logic          valid_o,
  output logic          valid_n_pulse_o
);
  logic      rst_s_n;
  logic      est_q;
  logic [3:0] cand_q;
  logic [3:0] cand_d;
  key_code_t code_q;
  key_code_t code_d;
  logic      valid_q;
  logic      held;
  logic      take;
  logic      load;

  dtmf_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  // Candidate key travels with the early flag.
  always_comb begin
    cand_d = cand_q;
    if (tone_hit) cand_d = {row_idx, col_idx};
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      est_q  <= 1'b0;
      cand_q <= '0;
    end else begin
      est_q  <= tone_hit;
      cand_q <= cand_d;
    end
  end

  dtmf_guard #(.GW(GW)) u_guard (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .tick    (tick_ms),
    .present (est_q),
    .on_thr  (hold_on_ms),
    .off_thr (hold_off_ms),
    .held    (held),
    .take    (take)
  );

  always_comb begin
    code_d = code_q;
    if (take) code_d = key_of(cand_q[3:2], cand_q[1:0]);
  end

  // Valid trails the guard by one register so the code settles first.
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      code_q  <= code_d;
      valid_q <= held;
    end
  end

  assign load = held & ~valid_q;

  dtmf_pulse #(.PULSE_MS(PULSE_MS)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .tick    (tick_ms),
    .load    (load),
    .pulse_n (valid_n_pulse_o)
  );

  assign early_o = est_q;
  assign guard_o = held;
  assign valid_o = valid_q;
  assign digit_o = out_en ? code_q : 4'bzzzz;
endmodule

// File: rtl/dtmf_steer_chk.sv
module dtmf_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tone_hit,
  input logic       early,
  input logic       guard,
  input logic       valid,
  input logic       pulse_n,
  input logic [3:0] code_q
);
  a_r1_early_rise: assert property (@(posedge clk) disable iff (!rst_n)
    tone_hit |=> early);
  a_r1_early_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_hit |=> !early);
  a_r2_accept_needs_tone: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(guard) |-> $past(early));
  a_r4_release_needs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(guard) |-> !$past(early));
  a_r3_code_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $stable(code_q));
  a_r5_code_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> $rose(guard));
  a_r7_pulse_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> !pulse_n);
  a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    guard |=> valid);
  a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !guard |=> !valid);
endmodule

bind dtmf_steer dtmf_steer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .tone_hit (tone_hit),
  .early    (early_o),
  .guard    (guard_o),
  .valid    (valid_o),
  .pulse_n  (valid_n_pulse_o),
  .code_q   (code_q)
);

// File: tb/sim_dtmf_steer.sv
module sim_dtmf_steer;
  localparam int CLK_NS = 10;
  localparam int TP     = 4;
  localparam int HON    = 3;
  localparam int HOFF   = 2;
  localparam int SMS    = 10;
  localparam int GAP    = 14;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_ms;
  logic       tone_hit;
  logic [1:0] row_idx;
  logic [1:0] col_idx;
  logic [5:0] hold_on_ms;
  logic [5:0] hold_off_ms;
  logic       out_en;
  logic       early_o;
  logic       guard_o;
  wire  [3:0] digit_o;
  logic       valid_o;
  logic       valid_n_pulse_o;

  int checks = 0;
  int bad    = 0;
  int pulses = 0;
  int accepts = 0;
  int run_len = 0;
  logic [3:0] last_code;
  logic [3:0] prev_digit;
  logic       prev_valid;
  logic       mon_on;

  dtmf_steer #(.GW(6), .PULSE_MS(SMS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .tone_hit(tone_hit),
    .row_idx(row_idx), .col_idx(col_idx), .hold_on_ms(hold_on_ms),
    .hold_off_ms(hold_off_ms), .out_en(out_en), .early_o(early_o),
    .guard_o(guard_o), .digit_o(digit_o), .valid_o(valid_o),
    .valid_n_pulse_o(valid_n_pulse_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_code(input int r, input int c);
    string keys = "123A456B789C*0#D";
    byte ch = keys[r*4 + c];
    if (ch >= "1" && ch <= "9") return 4'(ch - "0");
    case (ch)
      "0": return 4'd10;
      "*": return 4'd11;
      "#": return 4'd12;
      "A": return 4'd13;
      "B": return 4'd14;
      "C": return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

  task automatic ms_step(input int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1;
      @(posedge clk); #1;
      tick_ms = 1'b0;
      repeat (TP-1) @(posedge clk);
      #1;
    end
  endtask

  // Monitor: strobe length, strobe count, code settled before valid (R3, R7).
  always @(negedge clk) begin
    if (!mon_on) begin
      run_len    <= 0;
      prev_valid <= 1'b0;
    end else begin
      if (!valid_n_pulse_o) run_len <= run_len + 1;
      else if (run_len != 0) begin
        pulses <= pulses + 1;
        check("R7 strobe low cycles", run_len, SMS*TP - 1);
        run_len <= 0;
      end
      if (valid_o && !prev_valid) begin
        check("R3 code stable at valid rise", int'(digit_o), int'(prev_digit));
        check("R7 strobe low at valid rise", int'(valid_n_pulse_o), 0);
      end
      prev_valid <= valid_o;
      prev_digit <= digit_o;
    end
  end

  task automatic press(input int r, input int c, input int d);
    row_idx  = 2'(r);
    col_idx  = 2'(c);
    tone_hit = 1'b1;
    ms_step(d);
    check("R1 early high during tone", int'(early_o), 1);
    tone_hit = 1'b0;
    ms_step(1);
    check("R1 early low after tone", int'(early_o), 0);
    check("R2 accept vs duration", int'(valid_o), (d >= HON) ? 1 : 0);
    check("R10 guard matches valid", int'(guard_o), int'(valid_o));
    if (d >= HON) begin
      last_code = exp_code(r, c);
      accepts++;
    end
    ms_step(GAP);
    check("R4 released after gap", int'(valid_o), 0);
    check("R5 R6 latched code", int'(digit_o), int'(last_code));
  endtask

  initial begin
    rst_n = 1'b0; tick_ms = 1'b0; tone_hit = 1'b0; row_idx = '0; col_idx = '0;
    hold_on_ms = 6'(HON); hold_off_ms = 6'(HOFF); out_en = 1'b1;
    mon_on = 1'b0; last_code = 4'd0; prev_digit = 4'd0;
    repeat (3) @(posedge clk); #1;
    check("R9 code in reset", int'(digit_o), 0);
    check("R9 valid in reset", int'(valid_o), 0);
    check("R9 strobe in reset", int'(valid_n_pulse_o), 1);
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    mon_on = 1'b1;
    check("R9 early after reset", int'(early_o), 0);
    check("R9 guard after reset", int'(guard_o), 0);

    // R2 duration sweep across the present-guard limit.
    for (int d = 1; d <= HON + 2; d++) press(d % 4, (d * 3) % 4, d);

    // R6 all sixteen keys at the exact acceptance boundary.
    for (int k = 0; k < 16; k++) press(k / 4, k % 4, HON);

    // R2 one tick short leaves code unchanged.
    press(1, 1, HON - 1);

    // R4 dropout one tick short of absent window is bridged.
    row_idx = 2'd0; col_idx = 2'd1; tone_hit = 1'b1;
    ms_step(GAP);
    tone_hit = 1'b0;
    ms_step(HOFF - 1);
    row_idx = 2'd2; col_idx = 2'd2; tone_hit = 1'b1;
    ms_step(GAP);
    check("R4 bridged dropout keeps valid", int'(valid_o), 1);
    check("R4 bridged dropout keeps code", int'(digit_o), int'(exp_code(0, 1)));
    tone_hit = 1'b0;
    ms_step(GAP);
    accepts++;
    last_code = exp_code(0, 1);
    check("R4 single strobe for bridged", pulses, accepts);

    // R4 dropout exactly the absent window re-accepts.
    row_idx = 2'd3; col_idx = 2'd3; tone_hit = 1'b1;
    ms_step(GAP);
    tone_hit = 1'b0;
    ms_step(HOFF);
    row_idx = 2'd2; col_idx = 2'd2; tone_hit = 1'b1;
    ms_step(GAP);
    check("R4 reaccepted code", int'(digit_o), int'(exp_code(2, 2)));
    tone_hit = 1'b0;
    ms_step(GAP);
    accepts += 2;
    last_code = exp_code(2, 2);
    check("R4 R7 strobe count", pulses, accepts);

    // R8 tristate.
    out_en = 1'b0; #2;
    checks++;
    if (digit_o !== 4'bzzzz) begin
      bad++;
      $display("FAIL R8 bus released: actual=%b expected=zzzz", digit_o);
    end
    out_en = 1'b1; #2;
    check("R8 bus driven", int'(digit_o), int'(last_code));

    // R9 reset after an accepted key.
    mon_on = 1'b0;
    rst_n = 1'b0; #2;
    check("R9 code cleared", int'(digit_o), 0);
    check("R9 valid cleared", int'(valid_o), 0);
    check("R9 strobe idle", int'(valid_n_pulse_o), 1);
    repeat (2) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    check("R9 code after release", int'(digit_o), 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule